// File: doc/BRIEF.md
# Toggle Event Crossing Into a Half-Rate Clock

This block moves read-completion events from a fast clock into a second clock that runs at exactly half that frequency. The two clocks are edge-aligned: every slow rising edge coincides with a fast rising edge. A source in the fast domain signals each event by inverting a single toggle line. In the same fast cycle, it presents the data word and the destination tag that belong to that event.

The fast side captures the toggle, the data and the tag on the same fast edge. An event can therefore never be paired with the wrong data word, whichever half of the slow period it lands in. Each captured event goes into a small ring of slots. The slow side drains one slot per slow cycle and presents it as a one-cycle valid pulse with its data and tag.

The read pointer is shared directly between the two domains, which is safe only because the clocks are related. The write pointer is shared the same way. A burst of back-to-back fast-domain events is absorbed by the ring and played out on consecutive slow cycles in arrival order.

Top module: `toggle_half_rate_cross`

## Requirements
- R1: While `rst_n` is low, and after its release, `out_valid` stays low until a toggle change is seen. The level that `evt_toggle` holds when reset is released is not an event.
- R2: An event is a change of `evt_toggle` level between two consecutive fast edges. While the level is held, any change on `evt_data` or `evt_tag` produces no output.
- R3: Each event produces exactly one slow cycle with `out_valid` high. During that cycle, `out_data` and `out_tag` equal the values of `evt_data` and `evt_tag` on the fast edge that saw the toggle change.
- R4: Events leave in the order in which they arrived, including events only one fast cycle apart.
- R5: With no events pending, an event captured on a fast edge that does not coincide with a slow edge is presented from the next slow edge, one fast cycle later. An event captured on a fast edge shared with a slow edge is presented from the following slow edge, two fast cycles later.
- R6: Up to `DEPTH` events may be pending at once. Toggle changes on consecutive fast cycles are accepted, provided the pending count never exceeds `DEPTH`.
- R7: While two or more events are pending, `out_valid` stays high on consecutive slow cycles until the backlog is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Source clock, twice the rate of `clk_slow` |
| clk_slow | input | 1 | Destination clock, rising edges aligned with every second `clk_fast` rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to both clocks |
| evt_toggle | input | 1 | Event line; each level change is one event |
| evt_data | input | DATA_W | Data word belonging to the event, valid with the toggle change |
| evt_tag | input | TAG_W | Destination tag belonging to the event |
| out_valid | output | 1 | One slow cycle per delivered event |
| out_data | output | DATA_W | Data word of the delivered event |
| out_tag | output | TAG_W | Tag of the delivered event |

## Verification
The bench builds the block with its defaults: a ring of four slots, 32-bit data and 4-bit tags. The ring is small enough that bursts of three or four back-to-back toggles push the backlog close to its limit, which exercises wrap-around of both pointers many times over. Events are placed deliberately on both phases of the slow period, so both latency cases of R5 and the consecutive-drain case of R7 are measured at exact slow cycles. A long pseudo-random run with mixed odd and even gaps confirms ordering and pairing of data and tag.

// File: rtl/tgx_pkg.sv
package tgx_pkg;

  // Pending-entry count between two wrap-around pointers of width pw.
  function automatic logic [31:0] fill_level(input logic [31:0] wr,
                                             input logic [31:0] rd,
                                             input int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wr - rd) & mask;
  endfunction

  // One step of a wrap-around pointer of width pw.
  function automatic logic [31:0] ptr_step(input logic [31:0] p,
                                           input int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (p + 32'd1) & mask;
  endfunction

  // An event is any difference between the present and the last seen level.
  function automatic logic level_changed(input logic now_lvl, input logic seen_lvl);
    return now_lvl ^ seen_lvl;
  endfunction

endpackage

// File: rtl/tgx_fast_writer.sv
module tgx_fast_writer
  import tgx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WW    = 36
) (
  input  logic                         clk_fast,
  input  logic                         rst_n,
  input  logic                         evt_toggle,
  input  logic [WW-1:0]                evt_word,
  input  logic [$clog2(DEPTH):0]       rd_ptr,
  output logic [$clog2(DEPTH):0]       wr_ptr,
  output logic [WW-1:0]                rd_word
);

  localparam int SW = $clog2(DEPTH);
  localparam int PW = SW + 1;

  logic              tog_seen;
  logic              ev_push;
  logic [31:0]       fill_f;
  logic [31:0]       wr_next32;
  logic [WW-1:0]     slots [DEPTH];

  assign ev_push   = rst_n && level_changed(evt_toggle, tog_seen);
  assign fill_f    = fill_level(32'(wr_ptr), 32'(rd_ptr), PW);
  assign wr_next32 = ptr_step(32'(wr_ptr), PW);

  // During reset the seen level tracks the line, so its level at release
  // is never taken as an event.
  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      tog_seen <= evt_toggle;
      wr_ptr   <= '0;
    end else begin
      tog_seen <= evt_toggle;
      if (ev_push) wr_ptr <= wr_next32[PW-1:0];
    end
  end

  // Data and tag are stored on the same edge that sees the level change.
  always_ff @(posedge clk_fast) begin
    if (ev_push) slots[wr_ptr[SW-1:0]] <= evt_word;
  end

  assign rd_word = slots[rd_ptr[SW-1:0]];

  // A push may only happen while a slot is free.
  p_no_overflow_r6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ev_push |-> (fill_f < 32'(DEPTH)))
    else $error("writer: event arrived with every slot occupied");

  // A held toggle level leaves the write pointer where it is.
  p_quiet_hold_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (evt_toggle == tog_seen) |=> $stable(wr_ptr))
    else $error("writer: pointer moved without a toggle change");

endmodule

// File: rtl/tgx_slow_reader.sv
module tgx_slow_reader
  import tgx_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                          clk_slow,
  input  logic                          rst_n,
  input  logic [$clog2(DEPTH):0]        wr_ptr,
  input  logic [DATA_W+TAG_W-1:0]       rd_word,
  output logic [$clog2(DEPTH):0]        rd_ptr,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic [TAG_W-1:0]              out_tag
);

  localparam int PW = $clog2(DEPTH) + 1;
  localparam int WW = DATA_W + TAG_W;

  logic [31:0] fill_s;
  logic [31:0] rd_next32;
  logic        pop;

  assign fill_s    = fill_level(32'(wr_ptr), 32'(rd_ptr), PW);
  assign rd_next32 = ptr_step(32'(rd_ptr), PW);
  assign pop       = rst_n && (fill_s != 32'd0);

  always_ff @(posedge clk_slow) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= pop;
      if (pop) begin
        rd_ptr   <= rd_next32[PW-1:0];
        out_data <= rd_word[WW-1:TAG_W];
        out_tag  <= rd_word[TAG_W-1:0];
      end
    end
  end

  // The count seen by the slow side never exceeds the ring size.
  p_fill_bound_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
    fill_s <= 32'(DEPTH))
    else $error("reader: pending count above ring size");

  // A backlog of two or more drains on back-to-back slow cycles.
  p_drain_r7: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (fill_s >= 32'd2) |=> (out_valid && fill_s != 32'd0))
    else $error("reader: backlog not drained on consecutive cycles");

endmodule

// File: rtl/toggle_half_rate_cross.sv
module toggle_half_rate_cross #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk_fast,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              evt_toggle,
  input  logic [DATA_W-1:0] evt_data,
  input  logic [TAG_W-1:0]  evt_tag,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag
);

  localparam int PW = $clog2(DEPTH) + 1;
  localparam int WW = DATA_W + TAG_W;

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [WW-1:0] rd_word;
  logic [WW-1:0] evt_word;

  assign evt_word = {evt_data, evt_tag};

  tgx_fast_writer #(
    .DEPTH (DEPTH),
    .WW    (WW)
  ) u_writer (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .evt_toggle (evt_toggle),
    .evt_word   (evt_word),
    .rd_ptr     (rd_ptr),
    .wr_ptr     (wr_ptr),
    .rd_word    (rd_word)
  );

  tgx_slow_reader #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
  ) u_reader (
    .clk_slow  (clk_slow),
    .rst_n     (rst_n),
    .wr_ptr    (wr_ptr),
    .rd_word   (rd_word),
    .rd_ptr    (rd_ptr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
  );

  // Output stays quiet on the first slow cycle after reset release (R1).
  p_quiet_after_reset_r1: assert property (@(posedge clk_slow)
    $rose(rst_n) |-> !out_valid)
    else $error("top: valid during reset release");

endmodule

// File: tb/toggle_half_rate_cross_test.sv
module toggle_half_rate_cross_test;

  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;
  localparam int NVEC   = 16;
  localparam int NRAND  = 240;

  // {gap in fast cycles, tag, data}; the delivered word must equal the stimulus
  localparam logic [39:0] VEC [NVEC] = '{
    40'h31A0000001, 40'h12B0000002, 40'h13C0000003, 40'h24D0000004,
    40'h55E0000005, 40'h16F0000006, 40'h3710000007, 40'h2820000008,
    40'h1930000009, 40'h1A4000000A, 40'h1B5000000B, 40'h4C6000000C,
    40'h7D7000000D, 40'h2E8000000E, 40'h1F9000000F, 40'h30A0000010
  };

  logic              clk_fast = 1'b0;
  logic              clk_slow = 1'b0;
  logic              rst_n    = 1'b0;
  logic              evt_toggle = 1'b1;
  logic [DATA_W-1:0] evt_data = '0;
  logic [TAG_W-1:0]  evt_tag  = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic [TAG_W-1:0]  out_tag;

  int checks = 0;
  int failures = 0;
  int exp_wr = 0;
  int exp_rd = 0;
  int valid_seen = 0;
  logic [DATA_W-1:0] exp_data [1024];
  logic [TAG_W-1:0]  exp_tag  [1024];
  logic [31:0] lfsr = 32'h1BADC0DE;

  toggle_half_rate_cross #(.DEPTH(4), .DATA_W(DATA_W), .TAG_W(TAG_W)) uut (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .evt_toggle(evt_toggle), .evt_data(evt_data), .evt_tag(evt_tag),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
  );

  // 50 MHz fast clock; slow clock rises with every second fast rising edge.
  always #10 clk_fast = ~clk_fast;
  initial begin
    #10 clk_slow = 1'b1;
    forever #20 clk_slow = ~clk_slow;
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // Called right after a falling fast edge: flip the line and remember the word.
  task automatic fire(input logic [DATA_W-1:0] d, input logic [TAG_W-1:0] t);
    evt_toggle = ~evt_toggle;
    evt_data   = d;
    evt_tag    = t;
    exp_data[exp_wr] = d;
    exp_tag[exp_wr]  = t;
    exp_wr++;
  endtask

  // Scoreboard: every valid must match the oldest outstanding event (R3, R4).
  always @(negedge clk_slow) begin
    if (rst_n && out_valid) begin
      valid_seen++;
      if (exp_rd >= exp_wr) begin
        check(1'b0, "R3 unexpected valid", 64'(out_data), 64'd0);
      end else begin
        check(out_data == exp_data[exp_rd], "R4 data order",
              64'(out_data), 64'(exp_data[exp_rd]));
        check(out_tag == exp_tag[exp_rd], "R3 tag pairing",
              64'(out_tag), 64'(exp_tag[exp_rd]));
        exp_rd++;
      end
    end
  end

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    int gap;
    int prev_gap;

    // R1: toggle sits high through reset; release must not create an event
    repeat (6) @(negedge clk_fast);
    check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    base = valid_seen;
    repeat (8) @(negedge clk_slow);
    check(valid_seen == base, "R1 no event at release", 64'(valid_seen - base), 64'd0);

    // R2: data and tag wiggle with the toggle held
    base = valid_seen;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_fast);
      evt_data = 32'hFEED0000 + 32'(i);
      evt_tag  = 4'(i);
    end
    repeat (6) @(negedge clk_slow);
    check(valid_seen == base, "R2 held level silent", 64'(valid_seen - base), 64'd0);

    // R5 case A: capture on a fast edge between slow edges
    @(posedge clk_slow);
    @(negedge clk_fast);
    fire(32'hA5A50001, 4'h3);
    @(negedge clk_slow);
    check(out_valid == 1'b0, "R5 early (odd phase)", 64'(out_valid), 64'd0);
    @(negedge clk_slow);
    check(out_valid == 1'b1, "R5 next slow edge", 64'(out_valid), 64'd1);
    @(negedge clk_slow);
    check(out_valid == 1'b0, "R3 single pulse", 64'(out_valid), 64'd0);

    // R5 case B: capture on a fast edge shared with a slow edge
    @(posedge clk_slow);
    @(negedge clk_fast);
    @(negedge clk_fast);
    fire(32'hA5A50002, 4'h9);
    @(negedge clk_slow);
    check(out_valid == 1'b0, "R5 shared edge not seen", 64'(out_valid), 64'd0);
    @(negedge clk_slow);
    check(out_valid == 1'b1, "R5 two fast cycles later", 64'(out_valid), 64'd1);
    repeat (3) @(negedge clk_slow);

    // R7: three toggles on consecutive fast cycles drain back to back
    @(posedge clk_slow);
    @(negedge clk_fast); fire(32'hC0DE0001, 4'h1);
    @(negedge clk_fast); fire(32'hC0DE0002, 4'h2);
    @(negedge clk_fast); fire(32'hC0DE0003, 4'h3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_slow);
      check(out_valid == 1'b1, "R7 consecutive drain", 64'(out_valid), 64'd1);
    end
    @(negedge clk_slow);
    check(out_valid == 1'b0, "R7 backlog emptied", 64'(out_valid), 64'd0);

    // R6/R4: table walk with odd gaps and back-to-back bursts
    for (int v = 0; v < NVEC; v++) begin
      repeat (int'(VEC[v][39:36])) @(negedge clk_fast);
      fire(VEC[v][31:0], VEC[v][35:32]);
    end
    repeat (12) @(negedge clk_slow);
    check(exp_rd == exp_wr, "R6 table all delivered", 64'(exp_rd), 64'(exp_wr));

    // R4: pseudo-random spacing; a one-cycle gap is followed by at least three
    prev_gap = 4;
    for (int n = 0; n < NRAND; n++) begin
      lfsr = next_rand(lfsr);
      gap  = 1 + int'(lfsr[1:0]) + int'(lfsr[4] & lfsr[5]) * 3;
      if (prev_gap == 1 && gap < 3) gap = 3;
      prev_gap = gap;
      repeat (gap) @(negedge clk_fast);
      lfsr = next_rand(lfsr);
      fire(lfsr, lfsr[11:8]);
    end
    repeat (12) @(negedge clk_slow);
    check(exp_rd == exp_wr, "R4 random all delivered", 64'(exp_rd), 64'(exp_wr));
    check(valid_seen == exp_wr, "R3 one valid per event", 64'(valid_seen), 64'(exp_wr));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule